// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Sequencing

This block keeps a four-bank DDR SDRAM refreshed. An interval timer counts system clocks and adds one owed refresh to a debt counter every average refresh interval. When the debt is non-zero, the block raises a request toward the command arbiter. The arbiter grants only once every bank is precharged. The block then drives the auto-refresh pin pattern for one cycle and holds off further refreshes for the refresh cycle time. Refreshes can be postponed while the arbiter is busy, up to a debt of eight. At that point the block flags the request as urgent.

A self-refresh request uses the same handshake. On grant, the block drives the refresh pattern with the clock enable going low and stays in self refresh. While in self refresh the interval timer is paused and the debt is cleared. When the request is removed, the block raises the clock enable with a no-operation pattern. It then runs two separate hold-off windows: one gates non-read commands and one gates reads. A busy flag covers refresh recovery, the whole self-refresh stay and both hold-offs.

Top module: `refresh_sched`

## Requirements
- R1: While rst_ni is low, cke_o is 1, the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and req_o, urgent_o, busy_o, nrd_hold_o and rd_hold_o are 0.
- R2: The debt grows by one on every REFI_CYC-th clock edge counted while not in self refresh, starting from reset. req_o rises in the cycle after the first such edge.
- R3: A grant taken while req_o is high (and sr_req_i low) drives the refresh pattern (cs_n=0, ras_n=0, cas_n=0, we_n=1) in the next cycle for exactly one cycle, with cke_o high in that cycle and the one before it. NOP follows.
- R4: The debt saturates at DEBT_MAX=8. urgent_o is high exactly while the debt is 8 outside self refresh, and each refresh lowers the debt by one.
- R5: busy_o is high for TRFC_CYC cycles, starting with the refresh-pattern cycle. req_o stays low during that window.
- R6: Over any run without self refresh, the number of refresh commands equals the number of interval ticks, once pending debt is drained and no tick was lost to saturation.
- R7: sr_req_i raises req_o even with zero debt. A grant then drives the refresh pattern with cke_o falling in the same cycle. After that cycle the pins carry NOP, cke_o stays low, busy_o stays high and req_o stays low.
- R8: While in self refresh, the interval timer holds its count and the debt is cleared. After exit, the next request comes exactly when the paused count completes.
- R9: Dropping sr_req_i in self refresh raises cke_o with NOP in the next cycle. nrd_hold_o is then high for XSNR_CYC cycles and rd_hold_o for XSRD_CYC cycles from that cycle, busy_o covers both, and req_o is low while nrd_hold_o is high.
- R10: grant_i has no effect while req_o is low: no command pattern changes and cke_o does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Arbiter grant, all banks precharged |
| sr_req_i | input | 1 | Level request to enter and stay in self refresh |
| req_o | output | 1 | Request for the command slot |
| urgent_o | output | 1 | Debt at its ceiling |
| busy_o | output | 1 | Refresh recovery, self refresh or post-exit hold-off active |
| nrd_hold_o | output | 1 | Non-read commands blocked after self-refresh exit |
| rd_hold_o | output | 1 | Read commands blocked after self-refresh exit |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The hardest state to reach is a timer phase carried across self refresh while the debt is cleared. It only shows if self refresh starts with debt pending and lasts a time that is not a multiple of the interval. The stimulus waits for a tick-driven request and enters self refresh on that request. It stays for three intervals plus seven cycles, then checks that no request appears until the paused count completes. Saturation is reached by withholding grants for nine intervals, and random grants between drains test the refresh budget.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic {ST_RUN, ST_SELF} refsch_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } refsch_pins_t;

  localparam refsch_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam refsch_pins_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
endpackage

// File: rtl/refsch_interval.sv
module refsch_interval #(
  parameter int unsigned REFI_CYC = 1950,
  parameter int unsigned DEBT_MAX = 8,
  localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          take_i,
  output logic [DW-1:0] debt_o,
  output logic          pend_o,
  output logic          full_o
);
  logic [TW-1:0] cnt_q;
  logic [DW-1:0] debt_q;
  logic          tick;

  assign tick = run_i && (cnt_q == TW'(REFI_CYC - 1));

  // count holds while not running: pause, not restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) debt_q <= '0;
    else if (clr_i) debt_q <= '0;
    else if (tick && !take_i) begin
      if (debt_q != DW'(DEBT_MAX)) debt_q <= debt_q + 1'b1;
    end else if (!tick && take_i) begin
      debt_q <= debt_q - 1'b1;
    end
  end

  assign debt_o = debt_q;
  assign pend_o = (debt_q != '0);
  assign full_o = (debt_q == DW'(DEBT_MAX));
endmodule

// File: rtl/refsch_hold.sv
module refsch_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         active_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int unsigned REFI_CYC = 1950,
  parameter int unsigned TRFC_CYC = 18,
  parameter int unsigned XSNR_CYC = 200,
  parameter int unsigned XSRD_CYC = 200,
  parameter int unsigned DEBT_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  input  logic sr_req_i,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o,
  output logic nrd_hold_o,
  output logic rd_hold_o,
  output logic cke_o,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  import refsch_pkg::*;

  localparam int unsigned HMAX01 = (TRFC_CYC > XSNR_CYC) ? TRFC_CYC : XSNR_CYC;
  localparam int unsigned HMAX   = (HMAX01 > XSRD_CYC) ? HMAX01 : XSRD_CYC;
  localparam int          HW     = $clog2(HMAX + 1);
  localparam int          DW     = $clog2(DEBT_MAX + 1);
  localparam int          NHOLD  = 3; // 0: refresh recovery, 1: non-read, 2: read

  refsch_st_e   state_q;
  refsch_pins_t pins_q;
  logic         cke_q;
  logic [DW-1:0] debt;
  logic         pend, full, run;
  logic         take, go_sr, go_ref, sr_exit;
  logic [NHOLD-1:0] hold_ld, hold_act;

  assign run     = (state_q == ST_RUN);
  assign req_o   = run && !hold_act[0] && !hold_act[1] && (pend || sr_req_i);
  assign take    = req_o && grant_i;
  assign go_sr   = take && sr_req_i;
  assign go_ref  = take && !sr_req_i;
  assign sr_exit = (state_q == ST_SELF) && !sr_req_i;

  refsch_interval #(.REFI_CYC(REFI_CYC), .DEBT_MAX(DEBT_MAX)) u_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (go_sr || (state_q == ST_SELF)),
    .take_i (go_ref),
    .debt_o (debt),
    .pend_o (pend),
    .full_o (full)
  );

  always_comb hold_ld = {sr_exit, sr_exit, go_ref};

  for (genvar g = 0; g < NHOLD; g++) begin : g_hold
    localparam int unsigned HV = (g == 0) ? TRFC_CYC : ((g == 1) ? XSNR_CYC : XSRD_CYC);
    refsch_hold #(.W(HW)) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (hold_ld[g]),
      .val_i    (HW'(HV)),
      .active_o (hold_act[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cke_q   <= 1'b1;
      pins_q  <= PINS_NOP;
    end else begin
      pins_q <= PINS_NOP;
      if (go_sr) begin
        state_q <= ST_SELF;
        cke_q   <= 1'b0;
        pins_q  <= PINS_REF;
      end else if (go_ref) begin
        pins_q  <= PINS_REF;
      end else if (sr_exit) begin
        state_q <= ST_RUN;
        cke_q   <= 1'b1;
      end
    end
  end

  assign urgent_o   = run && full;
  assign busy_o     = (state_q == ST_SELF) || (|hold_act);
  assign nrd_hold_o = hold_act[1];
  assign rd_hold_o  = hold_act[2];
  assign cke_o      = cke_q;
  assign cs_n_o     = pins_q.cs_n;
  assign ras_n_o    = pins_q.ras_n;
  assign cas_n_o    = pins_q.cas_n;
  assign we_n_o     = pins_q.we_n;
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int unsigned DEBT_MAX = 8,
  localparam int DW = $clog2(DEBT_MAX + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          urgent_i,
  input logic          busy_i,
  input logic          nrd_hold_i,
  input logic          rd_hold_i,
  input logic          cke_i,
  input logic [3:0]    pins_i,
  input logic [DW-1:0] debt_i
);
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_NOP = 4'b0111;

  assert_ref_cke_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i == P_REF && cke_i) |-> $past(cke_i));

  assert_ref_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i == P_REF && cke_i) |-> (busy_i && !req_i));

  assert_debt_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debt_i <= DW'(DEBT_MAX));

  assert_urgent_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_i |-> (req_i || busy_i));

  assert_sr_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_i) |-> (pins_i == P_REF));

  assert_sr_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && $past(!cke_i)) |-> (pins_i == P_NOP && busy_i && !req_i));

  assert_exit_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_i) |-> (pins_i == P_NOP && nrd_hold_i && rd_hold_i && busy_i));

  assert_nrd_noreq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrd_hold_i |-> !req_i);

  assert_no_unasked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (pins_i != P_REF));
endmodule

bind refresh_sched refsch_chk #(.DEBT_MAX(DEBT_MAX)) u_refsch_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_o),
  .urgent_i   (urgent_o),
  .busy_i     (busy_o),
  .nrd_hold_i (nrd_hold_o),
  .rd_hold_i  (rd_hold_o),
  .cke_i      (cke_o),
  .pins_i     ({cs_n_o, ras_n_o, cas_n_o, we_n_o}),
  .debt_i     (debt)
);

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  localparam int REFI = 40;
  localparam int TRFC = 18;
  localparam int XSNR = 20;
  localparam int XSRD = 30;
  localparam int DMAX = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grant_i = 1'b0;
  logic sr_req_i = 1'b0;
  logic req_o, urgent_o, busy_o, nrd_hold_o, rd_hold_o, cke_o;
  logic cs_n_o, ras_n_o, cas_n_o, we_n_o;

  int total = 0;
  int bad = 0;
  int run_edges = 0;
  int refs = 0;
  int lost = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refresh_sched #(
    .REFI_CYC(REFI), .TRFC_CYC(TRFC), .XSNR_CYC(XSNR), .XSRD_CYC(XSRD), .DEBT_MAX(DMAX)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant_i), .sr_req_i(sr_req_i),
    .req_o(req_o), .urgent_o(urgent_o), .busy_o(busy_o),
    .nrd_hold_o(nrd_hold_o), .rd_hold_o(rd_hold_o), .cke_o(cke_o),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o)
  );

  function automatic logic [3:0] pat_ref();
    return 4'b0001;
  endfunction
  function automatic logic [3:0] pat_nop();
    return 4'b0111;
  endfunction
  function automatic int exp_ticks(int edges, int dropped);
    return edges / REFI - dropped;
  endfunction

  function automatic logic [3:0] pins();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic check(string rq, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic step();
    logic pc;
    pc = cke_o;
    @(posedge clk);
    #1;
    if (pc) run_edges++;
    if (cke_o && pins() == pat_ref()) refs++;
  endtask

  task automatic drain();
    grant_i = 1'b1;
    #0;
    while (req_o || busy_o) step();
    grant_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 cke", cke_o, 1);
    check("R1 pins", pins(), pat_nop());
    check("R1 req/urgent/busy", {req_o, urgent_o, busy_o, nrd_hold_o, rd_hold_o}, 0);
    @(negedge clk); rst_ni = 1'b1;
    #1;

    // R2 first tick
    repeat (REFI - 1) step();
    check("R2 req before tick", req_o, 0);
    step();
    check("R2 req after tick", req_o, 1);
    check("R4 urgent low debt 1", urgent_o, 0);

    // R4 saturation with grants withheld
    while (run_edges < DMAX * REFI - 1) step();
    check("R4 urgent below cap", urgent_o, 0);
    step();
    check("R4 urgent at cap", urgent_o, 1);
    repeat (REFI) step();
    lost = 1;
    check("R4 urgent saturated", urgent_o, 1);

    // R3/R5 one granted refresh
    grant_i = 1'b1;
    step();
    grant_i = 1'b0;
    check("R3 ref pattern", pins(), pat_ref());
    check("R3 cke high", cke_o, 1);
    check("R5 busy on issue", busy_o, 1);
    check("R5 req low on issue", req_o, 0);
    check("R4 urgent drops", urgent_o, 0);
    grant_i = 1'b1; // R10: ignored while busy
    step();
    check("R3 single cycle", pins(), pat_nop());
    for (int k = 2; k < TRFC; k++) begin
      step();
      check("R10 grant ignored in busy", pins(), pat_nop());
    end
    check("R5 busy last cycle", busy_o, 1);
    check("R5 req low in busy", req_o, 0);
    grant_i = 1'b0;
    step();
    check("R5 busy ends", busy_o, 0);
    check("R5 req back", req_o, 1);

    // R6 budget after drain
    drain();
    check("R6 budget directed", refs, exp_ticks(run_edges, lost));

    // R6 random grants
    for (int i = 0; i < 60 * REFI; i++) begin
      grant_i = ($urandom_range(0, 3) == 0);
      step();
      total++;
      if (req_o && busy_o) begin
        bad++;
        $display("FAIL R5: got req=1 busy=1 expected req=0");
      end
    end
    drain();
    check("R6 budget random", refs, exp_ticks(run_edges, lost));

    // R7/R8 self refresh with debt pending
    while (!req_o) step();
    check("R2 tick phase", run_edges % REFI, 0);
    sr_req_i = 1'b1; grant_i = 1'b1;
    step();
    grant_i = 1'b0;
    check("R7 entry pattern", pins(), pat_ref());
    check("R7 cke falls", cke_o, 0);
    check("R7 busy in sr", busy_o, 1);
    for (int k = 0; k < 3 * REFI + 7; k++) begin
      grant_i = $urandom_range(0, 1);
      step();
      if (k % 16 == 0) begin
        check("R7 cke held low", cke_o, 0);
        check("R7 nop in sr", pins(), pat_nop());
        check("R7 req low in sr", req_o, 0);
        check("R7 busy in sr", busy_o, 1);
      end
    end
    grant_i = 1'b0;
    check("R10 grant no exit", cke_o, 0);
    sr_req_i = 1'b0;
    step();
    check("R9 cke rises", cke_o, 1);
    check("R9 exit nop", pins(), pat_nop());
    check("R9 holds set", {nrd_hold_o, rd_hold_o, busy_o}, 3'b111);
    repeat (XSNR - 1) step();
    check("R9 nrd last", nrd_hold_o, 1);
    step();
    check("R9 nrd ends", nrd_hold_o, 0);
    check("R9 rd still", rd_hold_o, 1);
    check("R9 busy rd", busy_o, 1);
    repeat (XSRD - XSNR - 1) step();
    check("R9 rd last", rd_hold_o, 1);
    step();
    check("R9 rd ends", rd_hold_o, 0);
    check("R9 busy ends", busy_o, 0);
    check("R8 debt cleared", req_o, 0);
    while (run_edges % REFI != 0) begin
      if (req_o) check("R8 early req", req_o, 0);
      step();
    end
    check("R8 paused phase", req_o, 1);

    // R7 zero-debt request, R10 grant without request
    drain();
    sr_req_i = 1'b1; #1;
    check("R7 req w/o debt", req_o, 1);
    sr_req_i = 1'b0; #1;
    check("R10 req low", req_o, 0);
    grant_i = 1'b1;
    step();
    grant_i = 1'b0;
    check("R10 grant ignored pins", pins(), pat_nop());
    check("R10 grant ignored cke", cke_o, 1);
    check("R10 grant ignored busy", busy_o, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule